// File: doc/BRIEF.md
# Phase/Neutral Current Disagreement Monitor

This block watches two current-sense magnitudes, one taken on the phase conductor and one on the return (neutral) conductor. Both values arrive already filtered and averaged, one pair per sample strobe. The block decides which of the two feeds the energy computation. It also raises a fault level when the two disagree, which points to tampering or leakage to earth. Billing then goes on from the larger current.

Each decision has its own ratio threshold and its own qualification time. A mismatch must hold over a number of consecutive strobes before the fault level goes high. A swap of the billing channel needs a stricter ratio, held over a separate and longer strobe count. The fault level drops on the first strobe at which the channels agree again. The channel select does not follow it back. It only moves back once the other channel leads by the swap ratio, and this hysteresis prevents chatter. At light load, relative to a full-scale constant, both decisions are suspended. All ratio tests are integer cross-multiplications, so the block needs no divider. The strobe counts are parameters, so a test bench can use short timing.

Top module: `chan_fault_arbiter`

## Requirements
- R1: While reset is asserted and directly after it, `sel_b` is 0 (channel A bills) and `fault` is 0.
- R2: A strobe is a mismatch strobe when 1000·min(a,b) < 875·max(a,b) and it is not a light-load strobe. `fault` goes high at the clock edge of the FLT_TICKS-th consecutive mismatch strobe and stays high while mismatch strobes continue.
- R3: `fault` goes low at the clock edge of the first strobe that is not a mismatch strobe, whatever the state of `sel_b`.
- R4: Let "active" be the channel that `sel_b` selects (0 = A, 1 = B) and "inactive" the other one. A swap strobe is one that is not light-load and has 1000·inactive > 1140·active. At the edge of the SWP_TICKS-th consecutive swap strobe, `sel_b` toggles.
- R5: After a swap, `sel_b` returns only under the rule of R4 applied to the new active channel. An inactive channel that leads by less than 14% never causes a swap back.
- R6: A strobe with 1000·max(a,b) < 5·full_scale is a light-load strobe. It forces `fault` low at its edge, leaves `sel_b` unchanged and restarts both qualification counts.
- R7: A strobe that breaks a run of mismatch strobes restarts the fault count. A strobe that breaks a run of swap strobes restarts the swap count.
- R8: Cycles without `smp_vld` are ignored. Neither output changes, and no count advances or clears, whatever the magnitude inputs hold.
- R9: If channel B exceeds 114% of channel A from reset onward, B becomes the billing channel after SWP_TICKS strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe qualifying a new magnitude pair |
| mag_a | input | MAG_W | Averaged magnitude of channel A (phase), unsigned |
| mag_b | input | MAG_W | Averaged magnitude of channel B (neutral), unsigned |
| full_scale | input | MAG_W | Full-scale magnitude used for the light-load limit |
| sel_b | output | 1 | Billing channel select, 0 = A, 1 = B |
| fault | output | 1 | Channel disagreement flag |

## Verification
The hardest state to reach from the ports is a fault count or swap count paused one strobe short of expiry. Idle cycles with misleading magnitudes follow. The run then resumes and must expire on exactly one more strobe. The directed part of the bench builds this case with three mismatch strobes, a stretch of idle cycles holding blank or equal inputs, and a single strobe after that. A second directed case covers the band between 100% and 114% lead after a swap, where the fault must stay low and the select must not move. Random stimulus then holds each ratio for several strobes, so both counts expire often. It mixes light-load pairs and idle cycles into these runs.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    // Ratio constants, scaled by 1000 so no division is needed.
    localparam int unsigned K_SCALE = 1000;
    localparam int unsigned K_FAULT = 875;
    localparam int unsigned K_SWAP  = 1140;
    localparam int unsigned K_BLANK = 5;

    // Extra product bits: 1140 < 2^11.
    localparam int unsigned K_BITS  = 11;

    typedef struct packed {
        logic fault;
        logic sel_b;
    } cfa_state_t;

endpackage

// File: rtl/cfa_ratio_cmp.sv
module cfa_ratio_cmp
    import cfa_pkg::*;
#(
    parameter int unsigned MAG_W = 16
) (
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic [MAG_W-1:0] full_scale,
    input  logic             sel_b,
    output logic             light_load,
    output logic             mismatch,
    output logic             swap_req
);

    localparam int unsigned PROD_W = MAG_W + K_BITS;

    logic [MAG_W-1:0]  big_mag;
    logic [MAG_W-1:0]  small_mag;
    logic [MAG_W-1:0]  act_mag;
    logic [MAG_W-1:0]  inact_mag;
    logic [PROD_W-1:0] big_blank;
    logic [PROD_W-1:0] fs_blank;
    logic [PROD_W-1:0] small_scaled;
    logic [PROD_W-1:0] big_fault;
    logic [PROD_W-1:0] inact_scaled;
    logic [PROD_W-1:0] act_swap;

    always_comb begin
        if (mag_a >= mag_b) begin
            big_mag   = mag_a;
            small_mag = mag_b;
        end else begin
            big_mag   = mag_b;
            small_mag = mag_a;
        end
        act_mag   = sel_b ? mag_b : mag_a;
        inact_mag = sel_b ? mag_a : mag_b;

        big_blank    = PROD_W'(big_mag)    * PROD_W'(K_SCALE);
        fs_blank     = PROD_W'(full_scale) * PROD_W'(K_BLANK);
        small_scaled = PROD_W'(small_mag)  * PROD_W'(K_SCALE);
        big_fault    = PROD_W'(big_mag)    * PROD_W'(K_FAULT);
        inact_scaled = PROD_W'(inact_mag)  * PROD_W'(K_SCALE);
        act_swap     = PROD_W'(act_mag)    * PROD_W'(K_SWAP);

        light_load = big_blank < fs_blank;
        mismatch   = !light_load && (small_scaled < big_fault);
        swap_req   = !light_load && (inact_scaled > act_swap);
    end

endmodule

// File: rtl/cfa_qual_timer.sv
module cfa_qual_timer #(
    parameter int unsigned TICKS   = 1000,
    parameter bit          RESTART = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic cond,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = strobe && cond && (st_q.cnt >= LAST);
        if (strobe) begin
            if (!cond) begin
                st_d.cnt = '0;
            end else if (expire && RESTART) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != FULL) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a strobe with the condition false restarts the count.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && !cond |=> st_q.cnt == '0);

    // R7: the count never runs past its limit.
    p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    // R8: no strobe, no progress.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(st_q.cnt));

endmodule

// File: rtl/chan_fault_arbiter.sv
module chan_fault_arbiter
    import cfa_pkg::*;
#(
    parameter int unsigned MAG_W     = 16,
    parameter int unsigned FLT_TICKS = 1000,
    parameter int unsigned SWP_TICKS = 1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic [MAG_W-1:0] full_scale,
    output logic             sel_b,
    output logic             fault
);

    cfa_state_t st_d, st_q;

    logic light_load;
    logic mismatch;
    logic swap_req;
    logic flt_expire;
    logic swp_expire;

    cfa_ratio_cmp #(
        .MAG_W(MAG_W)
    ) i_cmp (
        .mag_a      (mag_a),
        .mag_b      (mag_b),
        .full_scale (full_scale),
        .sel_b      (st_q.sel_b),
        .light_load (light_load),
        .mismatch   (mismatch),
        .swap_req   (swap_req)
    );

    cfa_qual_timer #(
        .TICKS   (FLT_TICKS),
        .RESTART (1'b0)
    ) i_flt_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (smp_vld),
        .cond   (mismatch),
        .expire (flt_expire)
    );

    cfa_qual_timer #(
        .TICKS   (SWP_TICKS),
        .RESTART (1'b1)
    ) i_swp_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (smp_vld),
        .cond   (swap_req),
        .expire (swp_expire)
    );

    always_comb begin
        st_d = st_q;
        if (smp_vld) begin
            st_d.fault = mismatch && (st_q.fault || flt_expire);
            if (swp_expire) begin
                st_d.sel_b = ~st_q.sel_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_b = st_q.sel_b;
    assign fault = st_q.fault;

    // R2: the flag only rises on a qualifying mismatch strobe.
    p_fault_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fault) |-> $past(smp_vld && mismatch));

    // R3: a strobe without mismatch drops the flag.
    p_fault_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !mismatch |=> !st_q.fault);

    // R4: the select only moves on a swap strobe.
    p_swap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sel_b) |-> $past(smp_vld && swap_req));

    // R6: light load clears the flag and holds the select.
    p_light_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && light_load |=> !st_q.fault && $stable(st_q.sel_b));

    // R8: idle cycles change nothing.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(st_q.fault) && $stable(st_q.sel_b));

endmodule

// File: tb/test_chan_fault_arbiter.sv
`timescale 1ns/1ps
module test_chan_fault_arbiter;

    localparam int MW = 16;
    localparam int FT = 4;
    localparam int ST = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [MW-1:0] mag_a = '0;
    logic [MW-1:0] mag_b = '0;
    logic [MW-1:0] full_scale = 16'd50000;
    logic          sel_b;
    logic          fault;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit e_sel = 1'b0;
    bit e_flt = 1'b0;
    int fcnt = 0;
    int scnt = 0;

    always #2 clk = ~clk;

    chan_fault_arbiter #(
        .MAG_W(MW),
        .FLT_TICKS(FT),
        .SWP_TICKS(ST)
    ) i_chan_fault_arbiter (
        .clk(clk),
        .rst_n(rst_n),
        .smp_vld(smp_vld),
        .mag_a(mag_a),
        .mag_b(mag_b),
        .full_scale(full_scale),
        .sel_b(sel_b),
        .fault(fault)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit light(input longint a, input longint b, input longint fs);
        longint mx;
        mx = (a > b) ? a : b;
        return (1000 * mx) < (5 * fs);
    endfunction

    function automatic bit mism(input longint a, input longint b, input longint fs);
        longint mx, mn;
        mx = (a > b) ? a : b;
        mn = (a > b) ? b : a;
        return !light(a, b, fs) && ((1000 * mn) < (875 * mx));
    endfunction

    function automatic bit swp(input longint a, input longint b, input longint fs, input bit s);
        longint act, ina;
        act = s ? b : a;
        ina = s ? a : b;
        return !light(a, b, fs) && ((1000 * ina) > (1140 * act));
    endfunction

    task automatic model_step(input int a, input int b, input int fs);
        bit m, w;
        m = mism(a, b, fs);
        w = swp(a, b, fs, e_sel);
        if (m) begin
            if (fcnt < FT) fcnt++;
            e_flt = (fcnt == FT);
        end else begin
            fcnt  = 0;
            e_flt = 1'b0;
        end
        if (w) begin
            scnt++;
            if (scnt == ST) begin
                e_sel = ~e_sel;
                scnt  = 0;
            end
        end else begin
            scnt = 0;
        end
    endtask

    // Entered at a falling edge; leaves at the next falling edge.
    task automatic strobe(input int a, input int b, input string tag);
        mag_a   = MW'(a);
        mag_b   = MW'(b);
        smp_vld = 1'b1;
        model_step(a, b, int'(full_scale));
        @(negedge clk);
        smp_vld = 1'b0;
        chk(tag, "sel_b", int'(sel_b), int'(e_sel));
        chk(tag, "fault", int'(fault), int'(e_flt));
    endtask

    task automatic idle(input int a, input int b, input string tag);
        mag_a   = MW'(a);
        mag_b   = MW'(b);
        smp_vld = 1'b0;
        @(negedge clk);
        chk(tag, "sel_b idle", int'(sel_b), int'(e_sel));
        chk(tag, "fault idle", int'(fault), int'(e_flt));
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        chk("R1", "sel_b in reset", int'(sel_b), 0);
        chk("R1", "fault in reset", int'(fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sel_b after reset", int'(sel_b), 0);
        chk("R1", "fault after reset", int'(fault), 0);

        // R9 / R4 / R2: B twice A from the start.
        for (int i = 1; i <= ST; i++) begin
            strobe(10000, 20000, "R9");
            if (i == FT)     chk("R2", "fault at FT strobe", int'(fault), 1);
            if (i == ST - 1) chk("R4", "sel_b one short", int'(sel_b), 0);
        end
        chk("R9", "B selected", int'(sel_b), 1);
        chk("R2", "fault held", int'(fault), 1);

        // R5 / R3: A leads B by 10 percent: fault drops, no swap back.
        strobe(11000, 10000, "R3");
        chk("R3", "fault cleared without swap back", int'(fault), 0);
        for (int i = 0; i < 12; i++) strobe(11000, 10000, "R5");
        chk("R5", "no swap back at 110%", int'(sel_b), 1);
        for (int i = 0; i < ST; i++) strobe(12000, 10000, "R5");
        chk("R5", "swap back at 120%", int'(sel_b), 0);

        // R7: interrupted mismatch run restarts the count.
        for (int i = 0; i < 3; i++) strobe(10000, 8000, "R7");
        strobe(10000, 10000, "R7");
        for (int i = 0; i < 3; i++) strobe(10000, 8000, "R7");
        chk("R7", "no fault after broken run", int'(fault), 0);
        strobe(10000, 8000, "R7");
        chk("R7", "fault after full run", int'(fault), 1);
        strobe(10000, 9500, "R3");
        chk("R3", "fault cleared", int'(fault), 0);

        // R8: idle cycles with misleading inputs do not disturb a count.
        for (int i = 0; i < 3; i++) strobe(10000, 8000, "R8");
        idle(0, 0, "R8");
        idle(10000, 10000, "R8");
        idle(100, 60000, "R8");
        strobe(10000, 8000, "R8");
        chk("R8", "count resumed across idle", int'(fault), 1);

        // R6: light-load strobe clears fault and suspends swapping.
        strobe(200, 50, "R6");
        chk("R6", "fault cleared at light load", int'(fault), 0);
        for (int i = 0; i < ST + 2; i++) strobe(40, 240, "R6");
        chk("R6", "no swap at light load", int'(sel_b), 0);
        for (int i = 0; i < ST - 1; i++) strobe(1000, 2000, "R6");
        strobe(100, 200, "R6");
        for (int i = 0; i < ST - 1; i++) strobe(1000, 2000, "R6");
        chk("R6", "swap count restarted by light load", int'(sel_b), 0);
        strobe(1000, 2000, "R4");
        chk("R4", "swap after full run", int'(sel_b), 1);

        // Random runs holding a ratio for a few strobes.
        for (int run = 0; run < 900; run++) begin
            int ratio, a, b, len;
            case ($urandom_range(0, 7))
                0: ratio = 700;
                1: ratio = 870;
                2: ratio = 900;
                3: ratio = 1000;
                4: ratio = 1120;
                5: ratio = 1150;
                6: ratio = 1400;
                default: ratio = $urandom_range(500, 1600);
            endcase
            if ($urandom_range(0, 9) == 0) a = $urandom_range(10, 300);
            else                           a = $urandom_range(2000, 40000);
            len = $urandom_range(1, 9);
            for (int k = 0; k < len; k++) begin
                b = (a * ratio) / 1000 + $urandom_range(0, 3);
                if ($urandom_range(0, 1) == 1) strobe(a, b, "R2/R4/R6");
                else                           strobe(b, a, "R3/R5/R7");
                if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 65535), $urandom_range(0, 65535), "R8");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule